// File: doc/BRIEF.md
# Chip-Select Matcher with Spare Redirect

This block decides which memory rank answers a normalized DRAM input address. It holds no registers of its own: a bank of eight chip-select descriptors comes in on its ports. Each descriptor has a base, a mask and an enable bit. A lookup request carries the address.

Before comparing, the block forces fixed base and mask bits. The pattern depends on a revision-mode input. It then compares the address against every descriptor in parallel and picks the lowest-numbered enabled descriptor that matches.

An online-spare pair of inputs can name one rank as bad and another as its replacement. A hit on the bad rank is reported as the spare rank. The spare's own descriptor plays no part in that decision. The result is registered, appears one cycle after the request, and stays stable until the next request.

Top module: `csm_match_top`

## Requirements
- R1: Descriptor i hits when its enable bit is 1 and (address & ~effMask[i]) == (effBase[i] & ~effMask[i]), using the forced values defined in R3 and R4.
- R2: A descriptor whose enable bit is 0 never hits, even when its base and mask would match the address.
- R3: With revNew = 1, effBase = base & 0x1FF83FE0 and effMask = (mask | 0x0007C01F) & 0x1FFFFFFF.
- R4: With revNew = 0, effBase = base & 0xFFE0FE00 and effMask = (mask | 0x001F01FF) & 0x3FFFFFFF.
- R5: When several descriptors hit, respIndex reports the lowest hitting index.
- R6: When no descriptor hits, respNoMatch = 1 and respIndex = 0, with respRedirected = 0 and respSpareErr = 0.
- R7: When the winning index equals badCs, and badCs and spareCs are not both 4'hF, respIndex = spareCs and respRedirected = 1. The spare's enable, base and mask are not consulted.
- R8: When badCs and spareCs are both 4'hF (the invalid number), or the winning index differs from badCs, respIndex is the winning index and respRedirected = 0.
- R9: When the R7 condition holds but spareCs is 8 or more (4'hF included), respSpareErr = 1, respRedirected = 0 and respIndex keeps the winning index.
- R10: Results appear with respValid = 1 in the cycle after reqValid is sampled. With no new request they hold their values while respValid = 0. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Normalized DRAM input address |
| csBase | input | 8x32 | Base field of each chip-select descriptor |
| csMask | input | 8x32 | Mask field of each chip-select descriptor |
| csEnable | input | 8 | Enable bit of each descriptor |
| badCs | input | 4 | Rank named bad by the spare control (4'hF = none) |
| spareCs | input | 4 | Replacement rank number (4'hF = none) |
| revNew | input | 1 | 1 selects the newer forcing pattern, 0 the older |
| respValid | output | 1 | One-cycle pulse marking a fresh result |
| respIndex | output | 4 | Reported chip-select index |
| respRedirected | output | 1 | Result was remapped to the spare |
| respNoMatch | output | 1 | No descriptor hit |
| respSpareErr | output | 1 | Remap was wanted but the spare number is out of range |

## Verification
The hardest case to reach is a hit on the bad rank while the spare number is out of range. It needs a real hit, the priority winner equal to badCs, and an unusable spareCs, all at once. Random descriptors seldom produce that.

The bench builds random descriptors and then copies a chosen descriptor's base into the address, so that a hit is likely. It often sets badCs to that chosen index, and it draws spareCs from a range that includes 8, 9 and 4'hF. Directed cases add overlapping descriptors, disabled exact matches, and addresses that differ only in bits the two revision modes force differently.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int NUM_CS = 8;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;
  localparam logic [IDX_W-1:0] CS_NONE = '1;

  localparam logic [ADDR_W-1:0] NEW_BASE_KEEP = 32'h1FF8_3FE0;
  localparam logic [ADDR_W-1:0] NEW_MASK_SET  = 32'h0007_C01F;
  localparam logic [ADDR_W-1:0] NEW_MASK_KEEP = 32'h1FFF_FFFF;
  localparam logic [ADDR_W-1:0] OLD_BASE_KEEP = 32'hFFE0_FE00;
  localparam logic [ADDR_W-1:0] OLD_MASK_SET  = 32'h001F_01FF;
  localparam logic [ADDR_W-1:0] OLD_MASK_KEEP = 32'h3FFF_FFFF;

  typedef struct packed {
    logic loadResult;
    logic publish;
  } csmStrobes_t;
endpackage

// File: rtl/csm_cs_compare.sv
module csm_cs_compare
  import csm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              enable,
  input  logic              revNew,
  output logic              hit
);
  logic [ADDR_W-1:0] effBase;
  logic [ADDR_W-1:0] effMask;

  // R3 / R4: forced bits depend on the revision mode
  always_comb begin
    if (revNew) begin
      effBase = base & NEW_BASE_KEEP;
      effMask = (mask | NEW_MASK_SET) & NEW_MASK_KEEP;
    end else begin
      effBase = base & OLD_BASE_KEEP;
      effMask = (mask | OLD_MASK_SET) & OLD_MASK_KEEP;
    end
  end

  // R1 / R2: masked compare gated by enable
  assign hit = enable && ((addr & ~effMask) == (effBase & ~effMask));
endmodule

// File: rtl/csm_ctrl.sv
module csm_ctrl
  import csm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output csmStrobes_t strobes,
  output logic        respValid
);
  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= reqValid;
  end

  assign strobes.loadResult = reqValid;
  assign strobes.publish    = validQ;
  assign respValid          = validQ;

  p_valid_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  p_valid_drops_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
endmodule

// File: rtl/csm_datapath.sv
module csm_datapath
  import csm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  csmStrobes_t                   strobes,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [NUM_CS-1:0][ADDR_W-1:0] csBase,
  input  logic [NUM_CS-1:0][ADDR_W-1:0] csMask,
  input  logic [NUM_CS-1:0]             csEnable,
  input  logic [IDX_W-1:0]              badCs,
  input  logic [IDX_W-1:0]              spareCs,
  input  logic                          revNew,
  output logic [IDX_W-1:0]              respIndex,
  output logic                          respRedirected,
  output logic                          respNoMatch,
  output logic                          respSpareErr
);
  logic [NUM_CS-1:0] hitVec;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    csm_cs_compare u_cmp (
      .addr   (reqAddr),
      .base   (csBase[g]),
      .mask   (csMask[g]),
      .enable (csEnable[g]),
      .revNew (revNew),
      .hit    (hitVec[g])
    );
  end

  // R5: lowest index wins
  logic [IDX_W-1:0] winIdx;
  logic             anyHit;
  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  // R7 / R8 / R9: spare remap
  logic sparingOn, wantRemap, spareOk;
  logic [IDX_W-1:0] nextIdx;
  logic nextRedir, nextErr;
  always_comb begin
    sparingOn = !((badCs == CS_NONE) && (spareCs == CS_NONE));
    wantRemap = anyHit && sparingOn && (winIdx == badCs);
    spareOk   = spareCs < IDX_W'(NUM_CS);
    nextIdx   = winIdx;
    nextRedir = 1'b0;
    nextErr   = 1'b0;
    if (wantRemap) begin
      if (spareOk) begin
        nextIdx   = spareCs;
        nextRedir = 1'b1;
      end else begin
        nextErr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respIndex      <= '0;
      respRedirected <= 1'b0;
      respNoMatch    <= 1'b0;
      respSpareErr   <= 1'b0;
    end else if (strobes.loadResult) begin
      respIndex      <= nextIdx;
      respRedirected <= nextRedir;
      respNoMatch    <= !anyHit;
      respSpareErr   <= nextErr;
    end
  end

  p_nomatch_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.publish && respNoMatch) |-> (respIndex == '0 && !respRedirected && !respSpareErr));
  p_redirect_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    respRedirected |-> (!respSpareErr && !respNoMatch));
  p_redirect_to_spare_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadResult |=> (!respRedirected || respIndex == $past(spareCs)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadResult |=> ($stable(respIndex) && $stable(respNoMatch) && $stable(respRedirected)));
  p_index_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.publish |-> (respIndex < IDX_W'(NUM_CS)));
endmodule

// File: rtl/csm_match_top.sv
module csm_match_top
  import csm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [NUM_CS-1:0][ADDR_W-1:0] csBase,
  input  logic [NUM_CS-1:0][ADDR_W-1:0] csMask,
  input  logic [NUM_CS-1:0]             csEnable,
  input  logic [IDX_W-1:0]              badCs,
  input  logic [IDX_W-1:0]              spareCs,
  input  logic                          revNew,
  output logic                          respValid,
  output logic [IDX_W-1:0]              respIndex,
  output logic                          respRedirected,
  output logic                          respNoMatch,
  output logic                          respSpareErr
);
  csmStrobes_t strobes;

  csm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .strobes   (strobes),
    .respValid (respValid)
  );

  csm_datapath u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .reqAddr        (reqAddr),
    .csBase         (csBase),
    .csMask         (csMask),
    .csEnable       (csEnable),
    .badCs          (badCs),
    .spareCs        (spareCs),
    .revNew         (revNew),
    .respIndex      (respIndex),
    .respRedirected (respRedirected),
    .respNoMatch    (respNoMatch),
    .respSpareErr   (respSpareErr)
  );
endmodule

// File: tb/sim_csm_match_top.sv
module sim_csm_match_top;
  import csm_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [NUM_CS-1:0][ADDR_W-1:0] csBase = '0;
  logic [NUM_CS-1:0][ADDR_W-1:0] csMask = '0;
  logic [NUM_CS-1:0] csEnable = '0;
  logic [IDX_W-1:0] badCs = 4'hF;
  logic [IDX_W-1:0] spareCs = 4'hF;
  logic revNew = 1'b0;
  logic respValid, respRedirected, respNoMatch, respSpareErr;
  logic [IDX_W-1:0] respIndex;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  csm_match_top u0 (.*);

  function automatic bit expHit(int i);
    logic [31:0] b, m;
    if (revNew) begin
      b = csBase[i] & 32'h1FF83FE0;
      m = (csMask[i] | 32'h0007C01F) & 32'h1FFFFFFF;
    end else begin
      b = csBase[i] & 32'hFFE0FE00;
      m = (csMask[i] | 32'h001F01FF) & 32'h3FFFFFFF;
    end
    return csEnable[i] && ((reqAddr & ~m) == (b & ~m));
  endfunction

  task automatic check(string req, logic [3:0] eIdx, bit eRed, bit eNo, bit eErr);
    nChecks++;
    if (respValid !== 1'b1 || respIndex !== eIdx || respRedirected !== eRed ||
        respNoMatch !== eNo || respSpareErr !== eErr) begin
      nFails++;
      $display("FAIL %s: got v=%b idx=%0d red=%b no=%b err=%b exp v=1 idx=%0d red=%b no=%b err=%b",
               req, respValid, respIndex, respRedirected, respNoMatch, respSpareErr,
               eIdx, eRed, eNo, eErr);
    end
  endtask

  // Compute expected from the requirements, run one lookup, compare.
  task automatic lookup(string req);
    int win;
    logic [3:0] eIdx;
    bit eRed, eNo, eErr;
    win = -1;
    for (int i = 0; i < NUM_CS; i++) if (win < 0 && expHit(i)) win = i;
    eIdx = 0; eRed = 0; eNo = (win < 0); eErr = 0;
    if (win >= 0) begin
      eIdx = 4'(win);
      if (!(badCs == 4'hF && spareCs == 4'hF) && 4'(win) == badCs) begin
        if (spareCs < 8) begin eIdx = spareCs; eRed = 1; end
        else eErr = 1;
      end
    end
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(req, eIdx, eRed, eNo, eErr);
  endtask

  task automatic clearCs();
    csBase = '0; csMask = '0; csEnable = '0; badCs = 4'hF; spareCs = 4'hF;
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    logic [3:0] heldIdx;
    seedDummy = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R10: reset state
    nChecks++;
    if (respValid !== 0 || respIndex !== 0 || respRedirected !== 0 ||
        respNoMatch !== 0 || respSpareErr !== 0) begin
      nFails++;
      $display("FAIL R10 reset: got v=%b idx=%0d exp all zero", respValid, respIndex);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R6: nothing enabled
    clearCs(); reqAddr = 32'h1234_5678; lookup("R6 no match");

    // R2: exact match but disabled
    clearCs(); csBase[3] = 32'h0400_0000; reqAddr = 32'h0400_0000;
    revNew = 1; lookup("R2 disabled");
    csEnable[3] = 1; lookup("R1 enabled exact");

    // R5: overlap, lowest wins
    clearCs(); csEnable = 8'b1010_0100; csMask[2] = 32'h1FFF_FFFF; csMask[5] = 32'h1FFF_FFFF;
    csMask[7] = 32'h1FFF_FFFF; reqAddr = 32'h0ABC_0000; revNew = 1; lookup("R5 lowest index");

    // R3 vs R4: base bit 31 forced off in new mode only
    clearCs(); csEnable[0] = 1; csBase[0] = 32'h8000_0000; reqAddr = 32'h0000_001F;
    revNew = 1; lookup("R3 new mode forced bits");
    revNew = 0; lookup("R4 old mode base bit kept");
    reqAddr = 32'h8000_01FF; lookup("R4 old mode low bits masked");
    reqAddr = 32'h8000_0200; lookup("R4 old mode bit 9 compared");

    // R7: redirect to spare with spare disabled
    clearCs(); revNew = 1; csEnable[1] = 1; csBase[1] = 32'h0010_0000; reqAddr = 32'h0010_0000;
    badCs = 1; spareCs = 6; lookup("R7 redirect");
    // R8: bad differs
    badCs = 2; lookup("R8 bad differs");
    // R8: both invalid
    badCs = 4'hF; spareCs = 4'hF; lookup("R8 both invalid");
    // R9: spare out of range
    badCs = 1; spareCs = 4'hF; lookup("R9 spare invalid");
    spareCs = 4'd9; lookup("R9 spare nine");

    // R10: hold while idle
    heldIdx = respIndex;
    @(negedge clk);
    nChecks++;
    if (respValid !== 0 || respIndex !== heldIdx || respSpareErr !== 1) begin
      nFails++;
      $display("FAIL R10 hold: got v=%b idx=%0d err=%b exp v=0 idx=%0d err=1",
               respValid, respIndex, respSpareErr, heldIdx);
    end

    // Random mix covering R1 R2 R3 R4 R5 R7 R8 R9
    for (int t = 0; t < 400; t++) begin
      int pick;
      revNew = 1'($urandom);
      for (int i = 0; i < NUM_CS; i++) begin
        csBase[i] = $urandom;
        csMask[i] = $urandom & $urandom & $urandom;
        csEnable[i] = ($urandom % 4) != 0;
      end
      pick = $urandom % NUM_CS;
      reqAddr = csBase[pick] ^ ($urandom & 32'h0000_0FFF);
      case ($urandom % 4)
        0: begin badCs = 4'hF; spareCs = 4'hF; end
        1: begin badCs = 4'(pick); spareCs = 4'($urandom % 8); end
        2: begin badCs = 4'(pick); spareCs = 4'(8 + $urandom % 8); end
        default: begin badCs = 4'($urandom); spareCs = 4'($urandom); end
      endcase
      lookup("R1/R5/R7/R9 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule